// File: doc/BRIEF.md
# Programmable Interval Timer Channel

This block is one 16-bit down-counting timer channel together with the decoder for the control words that select and configure it. Software talks to it through two byte-wide ports: a data port that carries the count one byte at a time, low byte first, and a control port that takes configuration and snapshot commands. Counting advances on a single-cycle enable, `tick_en`, which the system pulses at the timer's base rate, nominally about 1.19318 MHz. The channel drives one output line, `timer_out`, whose behaviour depends on the selected counting mode.

Three modes are built. In terminal-count mode the output rises once when the count expires. In rate-generator mode the counter reloads from its period and drops the output for one tick interval each period. In square-wave mode the output toggles every half period. Counts are binary and always use the low-then-high byte access. BCD counting, the read-back command, single-byte access and gate inputs are not part of the block. Several channels share one control port by giving each a distinct `CHAN_ID`, and a control word addressed to another channel is ignored without error.

Top module: `pit_channel`

## Requirements
- R1: After reset `timer_out`, `rd_data` and `cfg_err` are 0, the mode is terminal-count, the counter is stopped, and both byte pointers point at the low byte.
- R2: A control word has select in bits 7:6, access in bits 5:4, mode in bits 3:1 and BCD in bit 0. Select 3 is always rejected. With select equal to `CHAN_ID`, access 01 or 10, BCD 1 with access 11, or a mode other than 0, 2 or 3 with access 11 is rejected. A rejected word pulses `cfg_err` high in the cycle after the write and changes no channel state. A word for another channel (select 0 to 2, not `CHAN_ID`) has no effect and raises no error.
- R3: A control word with access 00 (latch) copies the live count into a snapshot and returns the read pointer to the low byte, but only when no snapshot is pending. A second latch while one is pending changes nothing.
- R4: Data-port reads return the low byte and then the high byte, alternately, in `rd_data` one cycle after `rd_en`. A pending snapshot is read instead of the live count, and reading its high byte releases it, so later reads show the live count.
- R5: Writing the first (low) data byte replaces count bits 7:0, stops counting and forces `timer_out` low.
- R6: Writing the second (high) data byte replaces count bits 15:8, copies the 16-bit value into the period register and starts counting only if that value is nonzero. The output goes to its mode's start level: low in terminal-count mode, high in the other two.
- R7: In terminal-count mode with period P, `timer_out` rises on the P-th tick after arming; the count then holds at 0 and stops.
- R8: In rate-generator mode with period P of at least 2, on every P-th tick the count reloads to P and `timer_out` is low until the next tick, high otherwise.
- R9: In square-wave mode with period P, the live count runs over H = P/2 (rounded down, at least 1), and `timer_out`, high at arming, toggles on every H-th tick.
- R10: An accepted configuration word sets the mode, stops counting, returns the write pointer to the low byte and sets `timer_out` to 0 for terminal-count mode, 1 otherwise.
- R11: A read of the control port returns 0x00.
- R12: `timer_out` changes only at an edge where `tick_en` or `wr_en` was high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Counting enable, one cycle per timer tick |
| wr_en | input | 1 | Write strobe for the selected port |
| rd_en | input | 1 | Read strobe for the selected port |
| port_sel | input | 1 | 0 selects the data port, 1 the control port |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Registered read byte, valid one cycle after `rd_en` |
| timer_out | output | 1 | Channel output line |
| cfg_err | output | 1 | One-cycle pulse after a rejected control word |

## Verification
The assertions watch on every cycle that an error pulse only follows a control-port write and leaves the output untouched, that a low-byte write leaves the output low, that control-port reads return zero, and that the output never moves without a tick or a write. The count arithmetic of the three modes, the snapshot-versus-live selection, the byte-order flip-flop shared between snapshot and live reads, and the halt-then-arm sequence of the data port can only be shown by the bench's scenarios, which compare bytes read back and output levels against periods worked out by hand.

// File: rtl/pit_pkg.sv
package pit_pkg;

  typedef enum logic [2:0] {
    MD_TERMCNT = 3'd0,
    MD_RATE    = 3'd2,
    MD_SQUARE  = 3'd3
  } pit_mode_e;

  typedef struct packed {
    logic [1:0] sel;
    logic [1:0] acc;
    logic [2:0] mode;
    logic       bcd;
  } pit_cword_t;

  localparam logic [1:0] SEL_READBACK = 2'b11;
  localparam logic [1:0] ACC_SNAP     = 2'b00;
  localparam logic [1:0] ACC_LOHI     = 2'b11;

endpackage

// File: rtl/pit_ctrl_decode.sv
module pit_ctrl_decode
  import pit_pkg::*;
#(
  parameter int unsigned CHAN_ID = 0
) (
  input  logic [7:0] cword,
  output logic       cfg_ok,
  output logic       snap_ok,
  output logic       reject,
  output pit_mode_e  cfg_mode
);
  localparam logic [1:0] MY_SEL = CHAN_ID[1:0];

  pit_cword_t cw;
  logic       hit;
  logic       mode_ok;

  always_comb begin
    cw       = pit_cword_t'(cword);
    hit      = (cw.sel == MY_SEL) && (cw.sel != SEL_READBACK);
    mode_ok  = (cw.mode == MD_TERMCNT) || (cw.mode == MD_RATE) ||
               (cw.mode == MD_SQUARE);
    snap_ok  = hit && (cw.acc == ACC_SNAP);
    cfg_ok   = hit && (cw.acc == ACC_LOHI) && !cw.bcd && mode_ok;
    reject   = (cw.sel == SEL_READBACK) || (hit && !snap_ok && !cfg_ok);
    cfg_mode = pit_mode_e'(cw.mode);
  end

endmodule

// File: rtl/pit_count_core.sv
module pit_count_core
  import pit_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  logic                cfg_we,
  input  pit_mode_e           cfg_mode,
  input  logic                data_we,
  input  logic [BYTE_W-1:0]   data_byte,
  output logic [2*BYTE_W-1:0] live_cnt,
  output logic                wr_hi,
  output logic                out_q
);
  localparam int unsigned CW = 2 * BYTE_W;

  logic [CW-1:0] cnt_q, period_q, new_val;
  logic          run_q;
  pit_mode_e     mode_q;

  function automatic logic [CW-1:0] half_of(input logic [CW-1:0] v);
    logic [CW-1:0] h;
    h = v >> 1;
    return (h == '0) ? CW'(1) : h;
  endfunction

  assign new_val  = {data_byte, cnt_q[BYTE_W-1:0]};
  assign live_cnt = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      period_q <= '0;
      run_q    <= 1'b0;
      out_q    <= 1'b0;
      wr_hi    <= 1'b0;
      mode_q   <= MD_TERMCNT;
    end else if (cfg_we) begin
      mode_q <= cfg_mode;
      run_q  <= 1'b0;
      wr_hi  <= 1'b0;
      out_q  <= (cfg_mode != MD_TERMCNT);
    end else if (data_we) begin
      if (!wr_hi) begin
        cnt_q[BYTE_W-1:0] <= data_byte;
        run_q <= 1'b0;
        out_q <= 1'b0;
        wr_hi <= 1'b1;
      end else begin
        cnt_q    <= (mode_q == MD_SQUARE) ? half_of(new_val) : new_val;
        period_q <= new_val;
        run_q    <= (new_val != '0);
        out_q    <= (mode_q != MD_TERMCNT);
        wr_hi    <= 1'b0;
      end
    end else if (tick && run_q) begin
      unique case (mode_q)
        MD_RATE: begin
          if (cnt_q == CW'(1)) begin
            cnt_q <= period_q;
            out_q <= 1'b0;
          end else begin
            cnt_q <= cnt_q - CW'(1);
            out_q <= 1'b1;
          end
        end
        MD_SQUARE: begin
          if (cnt_q == CW'(1)) begin
            cnt_q <= half_of(period_q);
            out_q <= ~out_q;
          end else begin
            cnt_q <= cnt_q - CW'(1);
          end
        end
        default: begin
          cnt_q <= cnt_q - CW'(1);
          if (cnt_q == CW'(1)) begin
            out_q <= 1'b1;
            run_q <= 1'b0;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/pit_read_path.sv
module pit_read_path #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                snap_req,
  input  logic                rd_data_req,
  input  logic                rd_ctrl_req,
  input  logic [2*BYTE_W-1:0] live_cnt,
  output logic [BYTE_W-1:0]   rd_byte
);
  logic [2*BYTE_W-1:0] snap_q, src;
  logic                held_q;
  logic                rd_hi_q;

  assign src = held_q ? snap_q : live_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      snap_q  <= '0;
      held_q  <= 1'b0;
      rd_hi_q <= 1'b0;
      rd_byte <= '0;
    end else if (snap_req) begin
      if (!held_q) begin
        held_q  <= 1'b1;
        snap_q  <= live_cnt;
        rd_hi_q <= 1'b0;
      end
    end else if (rd_data_req) begin
      rd_byte <= rd_hi_q ? src[2*BYTE_W-1:BYTE_W] : src[BYTE_W-1:0];
      rd_hi_q <= ~rd_hi_q;
      if (rd_hi_q) held_q <= 1'b0;
    end else if (rd_ctrl_req) begin
      rd_byte <= '0;
    end
  end

endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pit_pkg::*;
#(
  parameter int unsigned BYTE_W  = 8,
  parameter int unsigned CHAN_ID = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              port_sel,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] rd_data,
  output logic              timer_out,
  output logic              cfg_err
);
  localparam int unsigned CW = 2 * BYTE_W;

  logic          ctl_wr, dat_wr;
  logic          cfg_ok, snap_ok, reject;
  pit_mode_e     cfg_mode;
  logic [CW-1:0] live_cnt;
  logic          wr_hi_ptr;

  assign ctl_wr = wr_en && port_sel;
  assign dat_wr = wr_en && !port_sel;

  pit_ctrl_decode #(.CHAN_ID(CHAN_ID)) u_dec (
    .cword   (wr_data[7:0]),
    .cfg_ok  (cfg_ok),
    .snap_ok (snap_ok),
    .reject  (reject),
    .cfg_mode(cfg_mode)
  );

  pit_count_core #(.BYTE_W(BYTE_W)) u_core (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick_en),
    .cfg_we   (ctl_wr && cfg_ok),
    .cfg_mode (cfg_mode),
    .data_we  (dat_wr),
    .data_byte(wr_data),
    .live_cnt (live_cnt),
    .wr_hi    (wr_hi_ptr),
    .out_q    (timer_out)
  );

  pit_read_path #(.BYTE_W(BYTE_W)) u_rd (
    .clk        (clk),
    .rst        (rst),
    .snap_req   (ctl_wr && snap_ok),
    .rd_data_req(rd_en && !port_sel),
    .rd_ctrl_req(rd_en && port_sel),
    .live_cnt   (live_cnt),
    .rd_byte    (rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) cfg_err <= 1'b0;
    else     cfg_err <= ctl_wr && reject;
  end

endmodule

// File: rtl/pit_channel_chk.sv
module pit_channel_chk #(
  parameter int unsigned BYTE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              tick_en,
  input logic              wr_en,
  input logic              rd_en,
  input logic              port_sel,
  input logic [BYTE_W-1:0] rd_data,
  input logic              timer_out,
  input logic              cfg_err,
  input logic              wr_hi_ptr
);

  // R2: an error pulse only follows a control-port write
  p_err_source_r2: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> $past(wr_en && port_sel));

  // R2: a rejected word leaves the output where it was
  p_err_keeps_out_r2: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> (timer_out == $past(timer_out)));

  // R5: the low-byte data write leaves the output low
  p_low_write_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !port_sel && !wr_hi_ptr) |=> !timer_out);

  // R11: control-port reads return zero
  p_ctrl_read_r11: assert property (@(posedge clk) disable iff (rst)
    (rd_en && port_sel) |=> (rd_data == '0));

  // R12: the output moves only on a tick or a write
  p_out_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    !$stable(timer_out) |-> $past(tick_en || wr_en));

endmodule

bind pit_channel pit_channel_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .tick_en  (tick_en),
  .wr_en    (wr_en),
  .rd_en    (rd_en),
  .port_sel (port_sel),
  .rd_data  (rd_data),
  .timer_out(timer_out),
  .cfg_err  (cfg_err),
  .wr_hi_ptr(wr_hi_ptr)
);

// File: tb/pit_channel_tb_top.sv
module pit_channel_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_en = 1'b0, wr_en = 1'b0, rd_en = 1'b0, port_sel = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       timer_out, cfg_err;
  int         errors = 0, checks = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  pit_channel dut_i (
    .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en), .rd_en(rd_en),
    .port_sel(port_sel), .wr_data(wr_data), .rd_data(rd_data),
    .timer_out(timer_out), .cfg_err(cfg_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input bit port, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; port_sel = port; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input bit port, output logic [7:0] v);
    @(negedge clk);
    rd_en = 1'b1; port_sel = port;
    @(negedge clk);
    rd_en = 1'b0;
    v = rd_data;
  endtask

  task automatic rd16(output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(1'b0, lo);
    rd(1'b0, hi);
    v = {hi, lo};
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic load(input logic [15:0] v);
    wr(1'b0, v[7:0]);
    wr(1'b0, v[15:8]);
  endtask

  // control words: sel[7:6] acc[5:4] mode[3:1] bcd[0]
  task automatic t_reset;
    chk("R1 out", timer_out, 0);
    chk("R1 rd_data", rd_data, 0);
    chk("R1 cfg_err", cfg_err, 0);
  endtask

  task automatic t_mode0;
    logic [15:0] v;
    wr(1'b1, 8'h30);
    chk("R10 mode0 out", timer_out, 0);
    load(16'd5);
    chk("R6 armed mode0 out low", timer_out, 0);
    ticks(4);
    chk("R7 before expiry", timer_out, 0);
    ticks(1);
    chk("R7 expiry out high", timer_out, 1);
    ticks(3);
    rd16(v);
    chk("R7 count holds at 0", v, 0);
  endtask

  task automatic t_latch;
    logic [15:0] v;
    logic [7:0]  b;
    wr(1'b1, 8'h30);
    load(16'h1234);
    wr(1'b1, 8'h00);
    ticks(3);
    wr(1'b1, 8'h00);
    chk("R3 second latch no error", cfg_err, 0);
    rd16(v);
    chk("R3 snapshot kept", v, 16'h1234);
    rd16(v);
    chk("R4 live after release", v, 16'h1231);
    rd(1'b0, b);
    chk("R4 live low", b, 8'h31);
    wr(1'b1, 8'h00);
    rd(1'b0, b);
    chk("R3 pointer back to low", b, 8'h31);
    rd(1'b0, b);
    chk("R4 snapshot high", b, 8'h12);
  endtask

  task automatic t_low_stop;
    logic [15:0] v;
    wr(1'b1, 8'h34);
    load(16'h0010);
    ticks(2);
    wr(1'b0, 8'h55);
    chk("R5 out forced low", timer_out, 0);
    ticks(5);
    rd16(v);
    chk("R5 stopped count", v, 16'h0055);
    wr(1'b0, 8'h00);
    chk("R6 arm rate out high", timer_out, 1);
    load(16'h0000);
    ticks(4);
    rd16(v);
    chk("R6 zero stays stopped", v, 0);
  endtask

  task automatic t_rate;
    logic [15:0] v;
    wr(1'b1, 8'h34);
    chk("R10 rate out high", timer_out, 1);
    load(16'd4);
    ticks(3);
    chk("R8 high before terminal", timer_out, 1);
    ticks(1);
    chk("R8 low at terminal", timer_out, 0);
    rd16(v);
    chk("R8 reload", v, 4);
    ticks(1);
    chk("R8 high again", timer_out, 1);
    ticks(3);
    chk("R8 second terminal", timer_out, 0);
  endtask

  task automatic t_square;
    logic [15:0] v;
    wr(1'b1, 8'h36);
    load(16'd6);
    chk("R9 start high", timer_out, 1);
    rd16(v);
    chk("R9 half count", v, 3);
    ticks(2);
    chk("R9 not yet", timer_out, 1);
    repeat (4) @(negedge clk);
    chk("R12 idle no change", timer_out, 1);
    ticks(1);
    chk("R9 toggle low", timer_out, 0);
    ticks(3);
    chk("R9 toggle high", timer_out, 1);
  endtask

  task automatic t_errors;
    logic [15:0] v;
    logic [7:0]  b;
    wr(1'b1, 8'h34);
    load(16'd9);
    wr(1'b1, 8'hF0);
    chk("R2 readback rejected", cfg_err, 1);
    wr(1'b1, 8'h10);
    chk("R2 access 01 rejected", cfg_err, 1);
    wr(1'b1, 8'h31);
    chk("R2 bcd rejected", cfg_err, 1);
    wr(1'b1, 8'h38);
    chk("R2 mode 4 rejected", cfg_err, 1);
    wr(1'b1, 8'h70);
    chk("R2 other channel no error", cfg_err, 0);
    chk("R2 out unchanged", timer_out, 1);
    ticks(2);
    rd16(v);
    chk("R2 still counting rate mode", v, 7);
    rd(1'b1, b);
    chk("R11 control read", b, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_mode0();
    t_latch();
    t_low_stop();
    t_rate();
    t_square();
    t_errors();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule